// File: doc/BRIEF.md
# Segment and Page Address Translator

This block is the front end that turns a 32-bit virtual address into a physical address. It does not hold any translation table itself. For each request it picks one of three paths. When translation is switched off, the address passes through unchanged. When the address falls in a directly mapped 256 MB region, the top four address bits are replaced by a base nibble taken from one of two base registers. Otherwise an external page-table lookup unit is asked for the 19-bit frame number of the 8 KB page, and that frame number is merged with the page offset.

Requests arrive on a valid/ready handshake, and one result leaves per accepted request, also on a valid/ready handshake. The block holds a single output slot. `req_ready` is high when that slot is empty or is being emptied in the same cycle (`!rsp_valid || rsp_ready`). While `rsp_valid` is high and `rsp_ready` is low, the result is frozen and no new request is taken. The page lookup port is combinational: the frame and miss answers must be valid in the same cycle as `tlb_query`.

Top module: `addr_xlate_top`

## Requirements
- R1: When both bits of `xlate_en` are 0, the result address equals the request address, the miss flag is 0 and `tlb_query` stays low.
- R2: With translation enabled, segment number s = `req_vaddr[31:28]` uses direct mapping when `seg_mode_map[s]` is 1, and the page path when it is 0.
- R3: The base nibble for segments 0 to 7 is `seg_base_lo[4s+3:4s]`, and for segments 8 to 15 it is `seg_base_hi[4(s-8)+3:4(s-8)]`. Segments 7 and 8 therefore read from different registers.
- R4: A directly mapped result is {base nibble, `req_vaddr[27:0]`} with the miss flag at 0, and no page lookup is issued.
- R5: On the page path, `tlb_query` is high in the accept cycle, with `tlb_vpage = req_vaddr[31:13]` and `tlb_write = req_write`. If `tlb_miss` is 0, the result is {`tlb_frame`, `req_vaddr[12:0]`} with the miss flag at 0.
- R6: On the page path with `tlb_miss` at 1, the result has the miss flag at 1 and an address of 0.
- R7: A request accepted at a clock edge shows `rsp_valid` high after that edge. If there is no new acceptance and the output is consumed or empty, `rsp_valid` drops at the next edge.
- R8: `req_ready = !rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, `rsp_paddr` and `rsp_miss` hold.
- R9: During reset and right after it, `rsp_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| xlate_en | input | 2 | Translation enable field; any nonzero value enables |
| seg_mode_map | input | 16 | Per-segment direct-mapping select |
| seg_base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| seg_base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| tlb_query | output | 1 | Page lookup issued this cycle |
| tlb_vpage | output | 19 | Virtual page number to look up |
| tlb_write | output | 1 | Lookup is for a write |
| tlb_frame | input | 19 | Frame number returned by lookup |
| tlb_miss | input | 1 | Lookup failed |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address |
| rsp_miss | output | 1 | Translation missed |

## Verification
A wrong mode decision shows up at once in the first result after it. A directly mapped address would show a lookup strobe and a page-style address, or a page address would come back with the wrong top nibble. A wrong nibble index shows as a wrong top nibble, most clearly on the segment 7/8 seam. A corrupted output slot shows up as a changed result during a stall, or as a lost or duplicated result one cycle after acceptance. The sweep covers every segment under every enable value and several map patterns, so every such fault appears within one transaction.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic [1:0] {
    XM_BYPASS = 2'd0,
    XM_SEG    = 2'd1,
    XM_PAGE   = 2'd2
  } xmode_t;
endpackage

// File: rtl/xlate_mode_sel.sv
module xlate_mode_sel
  import xlate_pkg::*;
#(
  parameter int SEG_BITS = 4
) (
  input  logic [1:0]             en_bits,
  input  logic [2**SEG_BITS-1:0] seg_map,
  input  logic [SEG_BITS-1:0]    seg,
  output xmode_t                 mode
);
  always_comb begin
    if (en_bits == 2'b00)   mode = XM_BYPASS;
    else if (seg_map[seg])  mode = XM_SEG;
    else                    mode = XM_PAGE;
  end
endmodule

// File: rtl/xlate_seg_base.sv
module xlate_seg_base #(
  parameter int SEG_BITS = 4
) (
  input  logic [SEG_BITS-1:0]                     seg,
  input  logic [(2**(SEG_BITS-1))*SEG_BITS-1:0]   base_lo,
  input  logic [(2**(SEG_BITS-1))*SEG_BITS-1:0]   base_hi,
  output logic [SEG_BITS-1:0]                     base
);
  localparam int HALF = 2**(SEG_BITS-1);

  logic [SEG_BITS-1:0] lo_nib [HALF];
  logic [SEG_BITS-1:0] hi_nib [HALF];

  for (genvar k = 0; k < HALF; k++) begin : g_nib
    assign lo_nib[k] = base_lo[k*SEG_BITS +: SEG_BITS];
    assign hi_nib[k] = base_hi[k*SEG_BITS +: SEG_BITS];
  end

  assign base = seg[SEG_BITS-1] ? hi_nib[seg[SEG_BITS-2:0]]
                                : lo_nib[seg[SEG_BITS-2:0]];
endmodule

// File: rtl/xlate_rsp_slot.sv
module xlate_rsp_slot #(
  parameter int W = 33
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import xlate_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int SEG_BITS  = 4,
  parameter int PAGE_BITS = 13
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [ADDR_W-1:0]                     req_vaddr,
  input  logic                                  req_write,
  input  logic [1:0]                            xlate_en,
  input  logic [2**SEG_BITS-1:0]                seg_mode_map,
  input  logic [(2**(SEG_BITS-1))*SEG_BITS-1:0] seg_base_lo,
  input  logic [(2**(SEG_BITS-1))*SEG_BITS-1:0] seg_base_hi,
  output logic                                  tlb_query,
  output logic [ADDR_W-PAGE_BITS-1:0]           tlb_vpage,
  output logic                                  tlb_write,
  input  logic [ADDR_W-PAGE_BITS-1:0]           tlb_frame,
  input  logic                                  tlb_miss,
  output logic                                  rsp_valid,
  input  logic                                  rsp_ready,
  output logic [ADDR_W-1:0]                     rsp_paddr,
  output logic                                  rsp_miss
);
  localparam int OFF_W = ADDR_W - SEG_BITS;

  xmode_t              mode;
  logic [SEG_BITS-1:0] seg;
  logic [SEG_BITS-1:0] base;
  logic [ADDR_W-1:0]   nxt_paddr;
  logic                nxt_miss;
  logic                accept;

  assign seg    = req_vaddr[ADDR_W-1 -: SEG_BITS];
  assign accept = req_valid && req_ready;

  xlate_mode_sel #(.SEG_BITS(SEG_BITS)) u_mode (
    .en_bits (xlate_en),
    .seg_map (seg_mode_map),
    .seg     (seg),
    .mode    (mode)
  );

  xlate_seg_base #(.SEG_BITS(SEG_BITS)) u_base (
    .seg     (seg),
    .base_lo (seg_base_lo),
    .base_hi (seg_base_hi),
    .base    (base)
  );

  assign tlb_query = accept && (mode == XM_PAGE);
  assign tlb_vpage = req_vaddr[ADDR_W-1:PAGE_BITS];
  assign tlb_write = req_write;

  always_comb begin
    nxt_paddr = req_vaddr;
    nxt_miss  = 1'b0;
    case (mode)
      XM_SEG:  nxt_paddr = {base, req_vaddr[OFF_W-1:0]};
      XM_PAGE: begin
        nxt_miss  = tlb_miss;
        nxt_paddr = tlb_miss ? '0 : {tlb_frame, req_vaddr[PAGE_BITS-1:0]};
      end
      default: nxt_paddr = req_vaddr;
    endcase
  end

  xlate_rsp_slot #(.W(ADDR_W + 1)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({nxt_miss, nxt_paddr}),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  ({rsp_miss, rsp_paddr})
  );
endmodule

// File: rtl/addr_xlate_chk.sv
module addr_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int SEG_BITS  = 4,
  parameter int PAGE_BITS = 13
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [ADDR_W-1:0]         req_vaddr,
  input logic [1:0]                xlate_en,
  input logic [2**SEG_BITS-1:0]    seg_mode_map,
  input logic                      tlb_query,
  input logic                      tlb_miss,
  input logic                      rsp_valid,
  input logic                      rsp_ready,
  input logic [ADDR_W-1:0]         rsp_paddr,
  input logic                      rsp_miss
);
  localparam int OFF_W = ADDR_W - SEG_BITS;
  logic acc;
  assign acc = req_valid && req_ready;

  p_bypass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc && xlate_en == 2'b00 |=> rsp_paddr == $past(req_vaddr) && !rsp_miss);

  p_query_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_query |-> xlate_en != 2'b00 && !seg_mode_map[req_vaddr[ADDR_W-1 -: SEG_BITS]]);

  p_seg_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc && xlate_en != 2'b00 && seg_mode_map[req_vaddr[ADDR_W-1 -: SEG_BITS]]
    |=> !rsp_miss && rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0]));

  p_page_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_query && tlb_miss |=> rsp_miss && rsp_paddr == '0);

  p_valid_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  p_valid_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid && (rsp_ready || !rsp_valid) |=> !rsp_valid);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_miss));

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
endmodule

bind addr_xlate_top addr_xlate_chk #(
  .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .PAGE_BITS(PAGE_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .xlate_en(xlate_en), .seg_mode_map(seg_mode_map),
  .tlb_query(tlb_query), .tlb_miss(tlb_miss), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_miss(rsp_miss)
);

// File: tb/addr_xlate_top_tb.sv
module addr_xlate_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  xlate_en = '0;
  logic [15:0] seg_mode_map = '0;
  logic [31:0] seg_base_lo = 32'h7654_3210 ^ 32'h9999_9999;
  logic [31:0] seg_base_hi = 32'hFEDC_BA98 ^ 32'h3333_3333;
  logic        tlb_query;
  logic [18:0] tlb_vpage;
  logic        tlb_write;
  logic [18:0] tlb_frame;
  logic        tlb_miss;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_miss;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // Bench page-table model: frame is a fixed scramble, miss when vpage[1:0]==3
  assign tlb_frame = tlb_vpage ^ 19'h2B3C1;
  assign tlb_miss  = (tlb_vpage[1:0] == 2'b11);

  addr_xlate_top u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] model(input logic [31:0] va);
    logic [3:0]  s;
    logic [3:0]  b;
    logic [18:0] vp;
    s  = va[31:28];
    vp = va[31:13];
    if (xlate_en == 2'b00) return {1'b0, va};
    if (seg_mode_map[s]) begin
      b = s < 8 ? seg_base_lo[4*s +: 4] : seg_base_hi[4*(s-8) +: 4];
      return {1'b0, b, va[27:0]};
    end
    if (vp[1:0] == 2'b11) return {1'b1, 32'h0};
    return {1'b0, vp ^ 19'h2B3C1, va[12:0]};
  endfunction

  function automatic string tag_of(input logic [31:0] va);
    if (xlate_en == 2'b00) return "R1";
    if (seg_mode_map[va[31:28]]) return (va[31:28] == 7 || va[31:28] == 8) ? "R3" : "R4";
    return (va[14:13] == 2'b11) ? "R6" : "R5";
  endfunction

  task automatic txn(input logic [31:0] va, input logic wr);
    logic [32:0] exp;
    bit pg;
    @(negedge clk);
    req_vaddr = va; req_write = wr; req_valid = 1'b1;
    exp = model(va);
    pg  = (xlate_en != 2'b00) && !seg_mode_map[va[31:28]];
    #1;
    chk(tlb_query == pg, pg ? "R5 query" : "R2 query", 64'(tlb_query), 64'(pg));
    if (pg) chk(tlb_vpage == va[31:13] && tlb_write == wr, "R5 lookup",
                {tlb_write, tlb_vpage}, {wr, va[31:13]});
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 valid", 64'(rsp_valid), 64'd1);
    chk({rsp_miss, rsp_paddr} == exp, tag_of(va), {rsp_miss, rsp_paddr}, exp);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] maps [4];
    maps[0] = 16'h0000; maps[1] = 16'hFFFF; maps[2] = 16'hA5C3; maps[3] = 16'h0180;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 reset", {rsp_valid, req_ready}, 64'b01);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R9 after", {rsp_valid, req_ready}, 64'b01);

    for (int e = 0; e < 4; e++) begin
      for (int m = 0; m < 4; m++) begin
        for (int s = 0; s < 16; s++) begin
          xlate_en = 2'(e);
          seg_mode_map = maps[m];
          txn({4'(s), 28'(32'h0ABC_DE1 * (s + 3 * m + 1) ^ (e << 13))}, 1'((s + m) & 1));
        end
      end
    end

    // Segment 7/8 seam with a single nibble distinct in each register
    xlate_en = 2'b10; seg_mode_map = 16'h0180;
    seg_base_lo = 32'h5000_0000; seg_base_hi = 32'h0000_000C;
    txn(32'h7123_4567, 1'b0);
    chk(rsp_paddr[31:28] == 4'h5, "R3 seg7", 64'(rsp_paddr[31:28]), 64'h5);
    txn(32'h8123_4567, 1'b1);
    chk(rsp_paddr[31:28] == 4'hC, "R3 seg8", 64'(rsp_paddr[31:28]), 64'hC);

    // Idle drop of valid
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 drop", 64'(rsp_valid), 64'd0);

    // Back-pressure
    xlate_en = 2'b00;
    rsp_ready = 1'b0;
    req_vaddr = 32'h1111_2222; req_valid = 1'b1;
    @(negedge clk);
    req_vaddr = 32'h3333_4444;
    chk(rsp_valid && rsp_paddr == 32'h1111_2222, "R8 first", rsp_paddr, 64'h1111_2222);
    chk(req_ready == 1'b0, "R8 ready low", 64'(req_ready), 64'd0);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == 32'h1111_2222, "R8 hold", rsp_paddr, 64'h1111_2222);
    end
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R8 ready high", 64'(req_ready), 64'd1);
    @(negedge clk);
    chk(rsp_valid && rsp_paddr == 32'h3333_4444, "R8 second", rsp_paddr, 64'h3333_4444);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R7 drain", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule